// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This unit executes one packed-halfword multiply-accumulate instruction. It decodes a 32-bit instruction word into four register indices, an operand pattern and an accumulate pattern. It presents the four indices as read addresses to an external file of 32-bit extension registers, and it takes the four read words back in the same cycle. From halves of the two source words it forms two signed 16x16 products. Each product is added to, or subtracted from, its own accumulator word.

The two results leave through two registered write ports, one clock after the instruction is presented. Each write port has an enable, an index and a data word. A control enable input gates the whole update. Index 0 is a zero register: it reads as zero and is never written. When both accumulators name the same register, only the right-lane write is issued. Both lanes always use the accumulator values that were read before any write.

Top module: `hmac_dual16`

## Requirements
- R1: The read indices come from fixed instruction fields: left accumulator A in bits 9:6, source B in bits 13:10, source C in bits 17:14, right accumulator D in bits 21:18. The operand pattern is in bits 23:22 and the accumulate pattern is in bits 25:24.
- R2: Each 16-bit half of B and C is taken as a signed two's-complement number before it is multiplied.
- R3: Operand pattern 0 gives left=B.hi*C.hi and right=B.lo*C.lo. Pattern 1 gives left=B.lo*C.hi and right=B.lo*C.lo. Pattern 2 gives left=B.hi*C.hi and right=B.hi*C.lo. Pattern 3 gives left=B.lo*C.hi and right=B.hi*C.lo.
- R4: Accumulate pattern bit 25 selects subtract (1) or add (0) for the left lane, which computes A±left. Bit 24 does the same for the right lane, which computes D±right.
- R5: Each result is the low 32 bits of the two's-complement sum or difference, and it wraps without saturation.
- R6: When the control enable input is low, no write strobe is raised.
- R7: When valid is low, no write strobe is raised, whatever the instruction and enable are.
- R8: A read of index 0 is taken as zero, whatever data the register file returns for it.
- R9: A write to index 0 is suppressed: its strobe stays low.
- R10: When A and D are the same index, only the right-lane (D) write is issued. Its value uses the accumulator as read before the instruction.
- R11: After reset both write strobes are low.
- R12: Results and strobes appear on the write ports in the cycle after the valid instruction, and they last for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| unit_en_i | input | 1 | Control-register enable bit |
| rs_a_idx_o | output | 4 | Read index for the left accumulator |
| rs_b_idx_o | output | 4 | Read index for source B |
| rs_c_idx_o | output | 4 | Read index for source C |
| rs_d_idx_o | output | 4 | Read index for the right accumulator |
| rs_a_dat_i | input | 32 | Read data for the left accumulator |
| rs_b_dat_i | input | 32 | Read data for source B |
| rs_c_dat_i | input | 32 | Read data for source C |
| rs_d_dat_i | input | 32 | Read data for the right accumulator |
| wa_en_o | output | 1 | Left-lane write strobe |
| wa_idx_o | output | 4 | Left-lane write index |
| wa_dat_o | output | 32 | Left-lane write data |
| wd_en_o | output | 1 | Right-lane write strobe |
| wd_idx_o | output | 4 | Right-lane write index |
| wd_dat_o | output | 32 | Right-lane write data |

## Verification
The assertions assume two things about the inputs. First, the register file answers a read index with its data combinationally, within the same cycle. Second, the writes it receives are applied before the next instruction reads the file. The bench keeps to both assumptions. Its register model responds to the index outputs at once and commits strobed writes on the clock edge after they appear. It also leaves one idle cycle after every instruction, so each instruction reads values that already include the previous writes. Random instruction words cover every index, including coincident and zero indices. The enable input is held high most of the time, so that most vectors carry out the update.

// File: rtl/hmac_dual16.sv
module hmac_dual16 #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic              unit_en_i,
  output logic [IDX_W-1:0]  rs_a_idx_o,
  output logic [IDX_W-1:0]  rs_b_idx_o,
  output logic [IDX_W-1:0]  rs_c_idx_o,
  output logic [IDX_W-1:0]  rs_d_idx_o,
  input  logic [WORD_W-1:0] rs_a_dat_i,
  input  logic [WORD_W-1:0] rs_b_dat_i,
  input  logic [WORD_W-1:0] rs_c_dat_i,
  input  logic [WORD_W-1:0] rs_d_dat_i,
  output logic              wa_en_o,
  output logic [IDX_W-1:0]  wa_idx_o,
  output logic [WORD_W-1:0] wa_dat_o,
  output logic              wd_en_o,
  output logic [IDX_W-1:0]  wd_idx_o,
  output logic [WORD_W-1:0] wd_dat_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int A_LSB  = 6;
  localparam int B_LSB  = A_LSB + IDX_W;
  localparam int C_LSB  = B_LSB + IDX_W;
  localparam int D_LSB  = C_LSB + IDX_W;
  localparam int OP_LSB = D_LSB + IDX_W;
  localparam int AP_LSB = OP_LSB + 2;
  localparam int TOP_USED = AP_LSB + 2;

  logic [1:0] opat, apat;
  assign rs_a_idx_o = instr_i[A_LSB +: IDX_W];
  assign rs_b_idx_o = instr_i[B_LSB +: IDX_W];
  assign rs_c_idx_o = instr_i[C_LSB +: IDX_W];
  assign rs_d_idx_o = instr_i[D_LSB +: IDX_W];
  assign opat       = instr_i[OP_LSB +: 2];
  assign apat       = instr_i[AP_LSB +: 2];

  wire unused_fields = ^{instr_i[31:TOP_USED], instr_i[A_LSB-1:0]};

  logic [WORD_W-1:0] a_w, b_w, c_w, d_w;
  assign a_w = (rs_a_idx_o == '0) ? '0 : rs_a_dat_i;
  assign b_w = (rs_b_idx_o == '0) ? '0 : rs_b_dat_i;
  assign c_w = (rs_c_idx_o == '0) ? '0 : rs_c_dat_i;
  assign d_w = (rs_d_idx_o == '0) ? '0 : rs_d_dat_i;

  logic signed [HALF_W-1:0] b_hi, b_lo, c_hi, c_lo, l_b, r_b;
  assign b_hi = b_w[WORD_W-1:HALF_W];
  assign b_lo = b_w[HALF_W-1:0];
  assign c_hi = c_w[WORD_W-1:HALF_W];
  assign c_lo = c_w[HALF_W-1:0];
  assign l_b  = opat[0] ? b_lo : b_hi;
  assign r_b  = opat[1] ? b_hi : b_lo;

  logic signed [WORD_W-1:0] prod_l, prod_r;
  assign prod_l = l_b * c_hi;
  assign prod_r = r_b * c_lo;

  logic [WORD_W-1:0] res_l, res_r;
  assign res_l = apat[1] ? a_w - prod_l : a_w + prod_l;
  assign res_r = apat[0] ? d_w - prod_r : d_w + prod_r;

  logic fire;
  assign fire = valid_i & unit_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_en_o  <= 1'b0;
      wd_en_o  <= 1'b0;
      wa_idx_o <= '0;
      wd_idx_o <= '0;
      wa_dat_o <= '0;
      wd_dat_o <= '0;
    end else begin
      wa_en_o  <= fire && (rs_a_idx_o != '0) && (rs_a_idx_o != rs_d_idx_o);
      wd_en_o  <= fire && (rs_d_idx_o != '0);
      wa_idx_o <= rs_a_idx_o;
      wd_idx_o <= rs_d_idx_o;
      wa_dat_o <= res_l;
      wd_dat_o <= res_r;
    end
  end

  // R6 R7
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && unit_en_i) |=> (!wa_en_o && !wd_en_o));

  // R9
  no_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en_o || wd_en_o) |-> ((!wa_en_o || wa_idx_o != '0) && (!wd_en_o || wd_idx_o != '0)));

  // R10
  no_dual_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en_o && wd_en_o) |-> (wa_idx_o != wd_idx_o));

  // R12
  d_lane_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && unit_en_i && rs_d_idx_o != '0) |=> (wd_en_o && wd_idx_o == $past(rs_d_idx_o)));

  // R12
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en_o |-> $past(valid_i && unit_en_i));
endmodule

// File: tb/hmac_dual16_tb_top.sv
module hmac_dual16_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0, unit_en_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [3:0] rs_a_idx_o, rs_b_idx_o, rs_c_idx_o, rs_d_idx_o, wa_idx_o, wd_idx_o;
  logic [31:0] rs_a_dat_i, rs_b_dat_i, rs_c_dat_i, rs_d_dat_i, wa_dat_o, wd_dat_o;
  logic wa_en_o, wd_en_o;
  logic [31:0] rf [16];
  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  hmac_dual16 dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .unit_en_i(unit_en_i),
    .rs_a_idx_o(rs_a_idx_o), .rs_b_idx_o(rs_b_idx_o), .rs_c_idx_o(rs_c_idx_o), .rs_d_idx_o(rs_d_idx_o),
    .rs_a_dat_i(rs_a_dat_i), .rs_b_dat_i(rs_b_dat_i), .rs_c_dat_i(rs_c_dat_i), .rs_d_dat_i(rs_d_dat_i),
    .wa_en_o(wa_en_o), .wa_idx_o(wa_idx_o), .wa_dat_o(wa_dat_o),
    .wd_en_o(wd_en_o), .wd_idx_o(wd_idx_o), .wd_dat_o(wd_dat_o));

  assign rs_a_dat_i = rf[rs_a_idx_o];
  assign rs_b_dat_i = rf[rs_b_idx_o];
  assign rs_c_dat_i = rf[rs_c_idx_o];
  assign rs_d_dat_i = rf[rs_d_idx_o];

  always @(posedge clk) begin
    if (wa_en_o) rf[wa_idx_o] <= wa_dat_o;
    if (wd_en_o) rf[wd_idx_o] <= wd_dat_o;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int a, input int b, input int c, input int d,
                                     input int op, input int ap);
    return {6'd0, 2'(ap), 2'(op), 4'(d), 4'(c), 4'(b), 4'(a), 6'd0};
  endfunction

  function automatic logic [31:0] rd(input logic [3:0] i);
    return (i == 0) ? 32'd0 : rf[i];
  endfunction

  function automatic int sx(input logic [15:0] h);
    return int'($signed(h));
  endfunction

  task automatic run_vec(input logic [31:0] ins, input logic en, input logic vld);
    logic [3:0] ia, ib, ic, id;
    logic [31:0] va, vb, vc, vd, ea, ed;
    int pl, pr;
    logic xa, xd;
    ia = ins[9:6]; ib = ins[13:10]; ic = ins[17:14]; id = ins[21:18];
    va = rd(ia); vb = rd(ib); vc = rd(ic); vd = rd(id);
    case (ins[23:22])
      2'd0: begin pl = sx(vb[31:16]) * sx(vc[31:16]); pr = sx(vb[15:0]) * sx(vc[15:0]); end
      2'd1: begin pl = sx(vb[15:0]) * sx(vc[31:16]); pr = sx(vb[15:0]) * sx(vc[15:0]); end
      2'd2: begin pl = sx(vb[31:16]) * sx(vc[31:16]); pr = sx(vb[31:16]) * sx(vc[15:0]); end
      default: begin pl = sx(vb[15:0]) * sx(vc[31:16]); pr = sx(vb[31:16]) * sx(vc[15:0]); end
    endcase
    ea = ins[25] ? va - 32'(pl) : va + 32'(pl);
    ed = ins[24] ? vd - 32'(pr) : vd + 32'(pr);
    xa = vld && en && ia != 0 && ia != id;
    xd = vld && en && id != 0;
    @(negedge clk);
    instr_i = ins; unit_en_i = en; valid_i = vld;
    #1;
    chk({rs_a_idx_o, rs_b_idx_o, rs_c_idx_o, rs_d_idx_o} == {ia, ib, ic, id}, "R1 indices",
        32'({rs_a_idx_o, rs_b_idx_o, rs_c_idx_o, rs_d_idx_o}), 32'({ia, ib, ic, id}));
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    chk(wa_en_o == xa, "R6/R7/R9/R10 left strobe", 32'(wa_en_o), 32'(xa));
    chk(wd_en_o == xd, "R6/R7/R9 right strobe", 32'(wd_en_o), 32'(xd));
    if (xa) begin
      chk(wa_idx_o == ia, "R1 left index", 32'(wa_idx_o), 32'(ia));
      chk(wa_dat_o == ea, "R2/R3/R4/R5/R8 left data", wa_dat_o, ea);
    end
    if (xd) begin
      chk(wd_idx_o == id, "R1 right index", 32'(wd_idx_o), 32'(id));
      chk(wd_dat_o == ed, "R2/R3/R4/R5/R8/R10 right data", wd_dat_o, ed);
    end
    @(posedge clk);
    @(negedge clk);
    chk(!wa_en_o && !wd_en_o, "R12 single-cycle strobe", 32'({wa_en_o, wd_en_o}), 32'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL R12 watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    rf[0] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R11
    chk(!wa_en_o && !wd_en_o, "R11 reset strobes", 32'({wa_en_o, wd_en_o}), 32'd0);
    rst_n = 1'b1;

    // R3 and R4: every pattern with distinct halves
    rf[5] = 32'h0003_0005; rf[6] = 32'h0007_000B;
    for (int op = 0; op < 4; op++)
      for (int ap = 0; ap < 4; ap++) begin
        rf[2] = 32'd1000; rf[3] = 32'd2000;
        run_vec(mk(2, 5, 6, 3, op, ap), 1'b1, 1'b1);
      end
    // R2: most negative halves
    rf[5] = 32'h8000_8000; rf[6] = 32'h8000_FFFF;
    run_vec(mk(2, 5, 6, 3, 0, 0), 1'b1, 1'b1);
    run_vec(mk(2, 5, 6, 3, 3, 3), 1'b1, 1'b1);
    // R5: wraparound
    rf[2] = 32'h7FFF_FFFF; rf[3] = 32'h8000_0000; rf[5] = 32'h0001_0001; rf[6] = 32'h0001_0001;
    run_vec(mk(2, 5, 6, 3, 0, 1), 1'b1, 1'b1);
    // R8: zero register as a source
    run_vec(mk(4, 0, 6, 7, 0, 0), 1'b1, 1'b1);
    run_vec(mk(0, 5, 6, 7, 1, 2), 1'b1, 1'b1);
    // R9: zero register as destination
    run_vec(mk(0, 5, 6, 0, 2, 0), 1'b1, 1'b1);
    // R10: same accumulator on both lanes
    run_vec(mk(7, 5, 6, 7, 0, 0), 1'b1, 1'b1);
    // R6: enable clear
    run_vec(mk(8, 9, 10, 11, 0, 0), 1'b0, 1'b1);
    // R7: valid low
    run_vec(mk(8, 9, 10, 11, 0, 0), 1'b1, 1'b0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ins;
      ins = $urandom;
      if (($urandom % 8) == 0) ins[21:18] = ins[9:6];
      if (($urandom % 16) == 0) for (int k = 0; k < 16; k++) rf[k] = $urandom;
      run_vec(ins, ($urandom % 8) != 0, ($urandom % 10) != 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule